// File: doc/BRIEF.md
# Systolic Plane-Wave Beam Filter Array

This block computes the nonseparable spatio-temporal section of a second-order frequency-planar plane-wave beam filter. It is built for a uniform linear antenna array. Each clock it takes one frame of signed fixed-point samples, one sample per antenna channel. Each clock it returns one filtered frame. The recursion runs along the space-time diagonal: the output of channel n for frame t depends on its own input, on channel n-1 at frame t-1 and on channel n-2 at frame t-2.

The array is a chain of identical processing cells, one per channel. Each cell talks only to its immediate neighbour, and a register sits on every link between cells. Each cell holds two internal pipeline stages: a multiply stage, then an add-and-saturate stage. Input samples are skewed by channel index so that the diagonal dependencies line up with those link registers, and the outputs are deskewed again so that a whole frame leaves the block at once.

The two feedback coefficients are elaboration-time parameters. The separable spatial and temporal sections, the converter front end and coefficient design are handled elsewhere.

Top module: `plane_wave_beam_array`

## Requirements
- R1: `valid_o` repeats `valid_i` after a fixed latency of N+1 register stages. A frame captured on clock edge t appears on `frame_o` and `valid_o` right after edge t+N.
- R2: For every channel n and frame t, the output is y(n,t) = sat(x(n,t) + fl(C1·y(n-1,t-1)/2^FRAC) + fl(C2·y(n-2,t-2)/2^FRAC)). Channel n occupies bits [n·W +: W] of both frame ports, and every sample is W-bit two's complement.
- R3: Spatial zero boundary: any term that needs a channel index below 0 contributes zero. As a result, channel 0 output equals its (gated) input unchanged.
- R4: Temporal zero boundary: after reset the recursion behaves as if every earlier frame were all zero, whatever state existed before the reset.
- R5: A cycle with `valid_i` low enters the recursion as an all-zero frame, whatever the value on `frame_i`.
- R6: Each sum is saturated to the W-bit signed range, giving 2^(W-1)-1 on positive overflow and -2^(W-1) on negative overflow. The saturated value is what is fed back to the neighbours.
- R7: Each product is truncated toward minus infinity by an arithmetic right shift of FRAC bits. For example, -1.25 becomes -2.
- R8: While `rst_ni` is low, `valid_o` is 0 and `frame_o` is all zero.
- R9: A new frame is accepted on every clock edge with no stall, so back-to-back frames each produce their own output frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one frame per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all state |
| valid_i | input | 1 | Marks `frame_i` as a real frame; when low, a zero frame is injected |
| frame_i | input | N·W | Input frame, channel n in bits [n·W +: W] |
| valid_o | output | 1 | `valid_i` delayed by N+1 stages |
| frame_o | output | N·W | Filtered frame, same channel layout |

## Verification
Every result is due exactly N edges after the edge that captures its frame. The bench therefore drives a frame at a falling edge, advances one falling edge, and compares the output against the reference frame driven N steps earlier. For the first N steps after reset it expects zeros and a low valid. Impulses are swept over every channel at several amplitudes, so that the diagonal propagation, the boundary terms and the floor rounding each land on a known cycle. Back-to-back random frames, gapped random frames, saturating plateaus and a reset in mid-stream complete the sweep.

// File: rtl/beam_pkg.sv
package beam_pkg;

  // width of the pre-saturation accumulator in a cell
  function automatic int acc_width(input int w, input int cw, input int frac);
    return w + cw - frac + 2;
  endfunction

  // register stages from input capture to the output port
  function automatic int array_latency(input int n_ch);
    return n_ch + 1;
  endfunction

endpackage

// File: rtl/beam_delay.sv
module beam_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] dly_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) dly_q[i] <= '0;
    end else begin
      dly_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  assign q_o = dly_q[DEPTH-1];

endmodule

// File: rtl/beam_ppcm.sv
module beam_ppcm #(
  parameter int W    = 16,
  parameter int CW   = 15,
  parameter int FRAC = 13,
  parameter int C1   = 10240,
  parameter int C2   = -4096
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] x_i,    // own channel sample, already skewed
  input  logic signed [W-1:0] nb_i,   // neighbour output, one frame back
  input  logic signed [W-1:0] far_i,  // second neighbour output, two frames back
  output logic signed [W-1:0] y_o
);

  localparam int PW = W + CW;
  localparam int SW = beam_pkg::acc_width(W, CW, FRAC);
  localparam logic signed [CW-1:0] K1 = CW'(C1);
  localparam logic signed [CW-1:0] K2 = CW'(C2);
  localparam logic signed [SW-1:0] HI = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [PW-1:0] m1_d, m2_d, m1_q, m2_q;
  logic signed [W-1:0]  x_q, y_d, y_q;
  logic signed [SW-1:0] sum;

  // stage 1: products
  assign m1_d = PW'(nb_i)  * PW'(K1);
  assign m2_d = PW'(far_i) * PW'(K2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      m1_q <= '0;
      m2_q <= '0;
    end else begin
      x_q  <= x_i;
      m1_q <= m1_d;
      m2_q <= m2_d;
    end
  end

  // stage 2: floor-shift, sum, saturate
  assign sum = SW'(x_q) + SW'(m1_q >>> FRAC) + SW'(m2_q >>> FRAC);

  always_comb begin
    if (sum > HI)      y_d = {1'b0, {(W-1){1'b1}}};
    else if (sum < LO) y_d = {1'b1, {(W-1){1'b0}}};
    else               y_d = W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= y_d;
  end

  assign y_o = y_q;

endmodule

// File: rtl/plane_wave_beam_array.sv
module plane_wave_beam_array #(
  parameter int N    = 10,
  parameter int W    = 16,
  parameter int CW   = 15,
  parameter int FRAC = 13,
  parameter int C1   = 10240,
  parameter int C2   = -4096
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [N*W-1:0] frame_i,
  output logic           valid_o,
  output logic [N*W-1:0] frame_o
);

  localparam int LAT = beam_pkg::array_latency(N);

  logic [N*W-1:0]      frame_g;
  logic [LAT-1:0]      vld_q;
  logic signed [W-1:0] cell_y [N];    // cell outputs
  logic signed [W-1:0] fwd    [N-1];  // fwd[n] feeds cell n+1 as far input

  assign frame_g = valid_i ? frame_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end
  assign valid_o = vld_q[LAT-1];

  for (genvar n = 0; n < N; n++) begin : gen_ch
    logic signed [W-1:0] x_sk, nb, far, y_al;

    // input skew: channel n waits n cycles
    if (n == 0) begin : gen_noskew
      assign x_sk = frame_g[W-1:0];
    end else begin : gen_skew
      beam_delay #(.W(W), .DEPTH(n)) u_skew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (frame_g[n*W +: W]),
        .q_o   (x_sk)
      );
    end

    // neighbour links; spatial boundary tied to zero
    if (n == 0) begin : gen_nb0
      assign nb = '0;
    end else begin : gen_nb
      assign nb = cell_y[n-1];
    end

    if (n == 0) begin : gen_far0
      assign far = '0;
    end else begin : gen_far
      assign far = fwd[n-1];
    end

    // forward of this cell's neighbour input, two frames deep
    if (n < N-1) begin : gen_fwd
      if (n == 0) begin : gen_fwd0
        assign fwd[n] = '0;
      end else begin : gen_fwdq
        beam_delay #(.W(W), .DEPTH(2)) u_fwd (
          .clk_i (clk_i),
          .rst_ni(rst_ni),
          .d_i   (cell_y[n-1]),
          .q_o   (fwd[n])
        );
      end
    end

    beam_ppcm #(
      .W(W), .CW(CW), .FRAC(FRAC), .C1(C1), .C2(C2)
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (x_sk),
      .nb_i  (nb),
      .far_i (far),
      .y_o   (cell_y[n])
    );

    // output deskew: channel n waits N-1-n cycles
    if (n == N-1) begin : gen_nodsk
      assign y_al = cell_y[n];
    end else begin : gen_dsk
      beam_delay #(.W(W), .DEPTH(N-1-n)) u_dsk (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (cell_y[n]),
        .q_o   (y_al)
      );
    end

    assign frame_o[n*W +: W] = y_al;
  end

endmodule

// File: rtl/beam_array_checker.sv
module beam_array_checker #(
  parameter int N = 10,
  parameter int W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [N*W-1:0] frame_i,
  input logic           valid_o,
  input logic [N*W-1:0] frame_o
);

  logic [N:0]   v_sh;
  logic [W-1:0] x0_sh [N+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sh <= '0;
      for (int i = 0; i <= N; i++) x0_sh[i] <= '0;
    end else begin
      v_sh     <= {v_sh[N-1:0], valid_i};
      x0_sh[0] <= valid_i ? frame_i[W-1:0] : '0;
      for (int i = 1; i <= N; i++) x0_sh[i] <= x0_sh[i-1];
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sh[N]);

  assert_ch0_passthrough_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o[W-1:0] == x0_sh[N]);

  assert_gap_zero_ch0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> frame_o[W-1:0] == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R8: assert (valid_o == 1'b0 && frame_o == '0);
    end
  end

endmodule

bind plane_wave_beam_array beam_array_checker #(.N(N), .W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .frame_i(frame_i),
  .valid_o(valid_o),
  .frame_o(frame_o)
);

// File: tb/plane_wave_beam_array_tb_top.sv
`timescale 1ns/1ps
module plane_wave_beam_array_tb_top;

  localparam int N    = 4;
  localparam int W    = 16;
  localparam int CW   = 15;
  localparam int FRAC = 13;
  localparam int C1   = 10240;
  localparam int C2   = -4096;
  localparam longint SMAX = 32767;
  localparam longint SMIN = -32768;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           vi = 1'b0;
  logic [N*W-1:0] fi = '0;
  logic           vo;
  logic [N*W-1:0] fo;

  always #2.5 clk = ~clk;

  plane_wave_beam_array #(
    .N(N), .W(W), .CW(CW), .FRAC(FRAC), .C1(C1), .C2(C2)
  ) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .valid_i(vi),
    .frame_i(fi),
    .valid_o(vo),
    .frame_o(fo)
  );

  int     checks = 0;
  int     fails  = 0;
  int     k      = 0;
  longint pr1 [N];
  longint pr2 [N];
  logic [N*W-1:0] exp_f [4096];
  bit             exp_v [4096];

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic logic [N*W-1:0] one_ch(input int ch, input int amp);
    logic [N*W-1:0] f = '0;
    f[ch*W +: W] = W'(amp);
    return f;
  endfunction

  task automatic model_clear();
    for (int n = 0; n < N; n++) begin
      pr1[n] = 0;
      pr2[n] = 0;
    end
    k = 0;
  endtask

  // drive one frame at a falling edge, advance one edge, compare the due result
  task automatic step(input bit v, input logic [N*W-1:0] f, input string tag);
    longint cur [N];
    int     j;
    bit     bad;
    vi = v;
    fi = f;
    for (int n = 0; n < N; n++) begin
      longint acc;
      acc = v ? longint'($signed(f[n*W +: W])) : 0;
      if (n >= 1) acc += (longint'(C1) * pr1[n-1]) >>> FRAC;
      if (n >= 2) acc += (longint'(C2) * pr2[n-2]) >>> FRAC;
      cur[n] = sat(acc);
    end
    for (int n = 0; n < N; n++) begin
      pr2[n] = pr1[n];
      pr1[n] = cur[n];
      exp_f[k][n*W +: W] = cur[n][W-1:0];
    end
    exp_v[k] = v;
    @(negedge clk);
    j = k - N;
    checks++;
    bad = 1'b0;
    if (vo !== ((j >= 0) ? exp_v[j] : 1'b0)) begin
      bad = 1'b1;
      $display("FAIL %s R1 vec %0d valid got %0b exp %0b", tag, j, vo,
               (j >= 0) ? exp_v[j] : 1'b0);
    end
    for (int n = 0; n < N; n++) begin
      logic signed [W-1:0] ex;
      logic signed [W-1:0] got;
      ex  = (j >= 0) ? exp_f[j][n*W +: W] : '0;
      got = fo[n*W +: W];
      if (got !== ex) begin
        bad = 1'b1;
        $display("FAIL %s vec %0d ch%0d got %0d exp %0d", tag, j, n, got, ex);
      end
    end
    if (bad) fails++;
    k++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vi    = 1'b0;
    fi    = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (vo !== 1'b0 || fo !== '0) begin
        fails++;
        $display("FAIL R8 reset outputs got v=%0b f=%h exp v=0 f=0", vo, fo);
      end
    end
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < N + 12; i++) step(1'b1, '0, tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int amps [4];
    amps[0] = 1; amps[1] = -1; amps[2] = 8191; amps[3] = -30000;
    model_clear();
    do_reset();                                  // R8

    // impulse sweep: diagonal propagation, spatial boundary, floor rounding
    for (int ch = 0; ch < N; ch++) begin
      for (int a = 0; a < 4; a++) begin
        step(1'b1, one_ch(ch, amps[a]), "R2 R3 R7 impulse");
        flush("R2 R3 R7 tail");
      end
    end

    // back-to-back random frames
    for (int i = 0; i < 300; i++) begin
      logic [N*W-1:0] f;
      for (int n = 0; n < N; n++) f[n*W +: W] = W'($signed(16'($urandom)) >>> 2);
      step(1'b1, f, "R2 R9 stream");
    end

    // gapped frames: junk on frame_i while invalid
    for (int i = 0; i < 300; i++) begin
      logic [N*W-1:0] f;
      for (int n = 0; n < N; n++) f[n*W +: W] = W'($urandom);
      step(($urandom % 3) != 0, f, "R5 gaps");
    end
    flush("R5 tail");

    // saturation plateaus, both signs
    for (int i = 0; i < 30; i++) step(1'b1, {N{16'sh7fff}}, "R6 positive");
    for (int i = 0; i < 30; i++) step(1'b1, {N{16'sh8000}}, "R6 negative");
    for (int i = 0; i < 20; i++) step(1'b1, {N{16'sh6000}}, "R6 recover");

    // reset in mid-stream with nonzero state, then zero-boundary response
    for (int i = 0; i < 10; i++) step(1'b1, {N{16'sh4000}}, "R4 preload");
    do_reset();
    step(1'b1, one_ch(0, -1), "R4 R7 fresh impulse");
    flush("R4 tail");
    step(1'b1, one_ch(1, 12345), "R4 R3 fresh impulse");
    flush("R4 tail");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule